// File: doc/BRIEF.md
# Kernel Cache Maintenance Tracker

This block follows the two cache maintenance phases that surround one kernel: the invalidate phase before it runs and the writeback (flush) phase after it. A request issuer outside the block pulses increment strobes as it sends invalidate or writeback requests, and the completion path pulses decrement strobes as they retire. Each strobe carries an amount, so several requests can be counted in one cycle. The block keeps both pending counts and reports whether each phase is finished.

The invalidate count has three kinds of value. A sentinel value of -1 means the phase has not begun. Zero means the phase is finished, or that it started in this very cycle with nothing yet pending. A positive value is the number of requests still outstanding. A force-done strobe can end the invalidate phase at any time. Any update that would drive a count below zero is refused and raises a sticky error. A kernel clear strobe returns everything to the idle state.

Top module: `kcm_tracker`

## Requirements
- R1: After reset, inv_count_o is -1 (all ones, two's complement, CNT_W+1 bits), inv_started_o and inv_done_o are 0, wb_count_o is 0, wb_done_o is 1 and count_err_o is 0.
- R2: kern_clear_i restores the R1 state on the next clock edge and overrides every other strobe in that cycle.
- R3: With neither clear nor force active, an invalidate update (inc or dec strobe) sets the count to base + inc_amt - dec_amt on the next edge. The base is 0 while the count is -1 and the count itself otherwise. A disabled strobe contributes 0, and a cycle with no strobe leaves the count unchanged.
- R4: inv_started_o is 1 exactly when inv_count_o is not -1, and inv_done_o is 1 exactly when inv_count_o is 0. An update from -1 whose net amount is zero moves the count to 0, so the phase is both started and done.
- R5: inv_force_i (without clear) sets the invalidate count to 0 on the next edge, whatever the current count and whatever invalidate inc or dec strobes arrive in the same cycle.
- R6: The writeback count follows the same update rule from a base equal to its current value. wb_done_o is 1 exactly when wb_count_o is 0.
- R7: An update whose result would be below zero leaves that counter unchanged and sets count_err_o on the same edge. The other counter still applies its own update in that cycle. A decrement while the invalidate count is -1 is refused in this way.
- R8: count_err_o stays 1 until a kernel clear or a reset.
- R9: When an inc and a dec strobe on the same counter are active in the same cycle, only their net difference is applied. The update is accepted whenever that net result is not negative, even if the decrement alone would underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kern_clear_i | input | 1 | Return both phases to idle and clear the error |
| inv_inc_en_i | input | 1 | Invalidate requests issued this cycle |
| inv_inc_amt_i | input | AMT_W | Number of invalidate requests issued |
| inv_dec_en_i | input | 1 | Invalidate requests retired this cycle |
| inv_dec_amt_i | input | AMT_W | Number of invalidate requests retired |
| inv_force_i | input | 1 | Force the invalidate phase to done |
| wb_inc_en_i | input | 1 | Writeback requests issued this cycle |
| wb_inc_amt_i | input | AMT_W | Number of writeback requests issued |
| wb_dec_en_i | input | 1 | Writeback requests retired this cycle |
| wb_dec_amt_i | input | AMT_W | Number of writeback requests retired |
| inv_started_o | output | 1 | Invalidate phase has begun |
| inv_done_o | output | 1 | Invalidate phase finished |
| inv_count_o | output | CNT_W+1 | Signed pending invalidate count, -1 when not begun |
| wb_done_o | output | 1 | No writeback request pending |
| wb_count_o | output | CNT_W | Pending writeback count |
| count_err_o | output | 1 | Sticky: an update was refused for underflow |

## Verification
Directed cases cover several distinct situations. A decrement from the sentinel tells a refused update apart from a silent wrap. A zero-net update from the sentinel tells "started" apart from "done". A force combined with adjustments separates the override from the adjustment path. Equal inc and dec amounts, and a dec larger than the count offset by a larger inc, show that the net difference is judged and not the decrement alone. A writeback underflow alongside a valid invalidate update shows that the two counters are independent. Long random runs mix every strobe with occasional clears, which exercises error stickiness and clear priority against a bench model.

// File: rtl/kcm_pkg.sv
package kcm_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_FORCE = 2'd2,
        OP_ADJ   = 2'd3
    } kcm_op_e;

    // Priority: clear, then force, then adjustment.
    function automatic kcm_op_e kcm_pick_op(input logic clr, input logic frc,
                                            input logic adj);
        if (clr)      return OP_CLEAR;
        else if (frc) return OP_FORCE;
        else if (adj) return OP_ADJ;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/kcm_counter.sv
module kcm_counter
    import kcm_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int AMT_W        = 4,
    parameter bit HAS_SENTINEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             force_i,
    input  logic             inc_en_i,
    input  logic [AMT_W-1:0] inc_amt_i,
    input  logic             dec_en_i,
    input  logic [AMT_W-1:0] dec_amt_i,
    output logic             idle_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reject_o
);

    localparam int NW = CNT_W + 2;

    typedef struct packed {
        logic             idle;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    localparam ctr_t RST_VAL = '{idle: HAS_SENTINEL, cnt: '0};

    ctr_t        st_d, st_q;
    logic        rej_d;
    kcm_op_e     op_d;
    logic [NW-1:0] base_d, inc_d, dec_d, net_d;

    always_comb begin
        st_d   = st_q;
        rej_d  = 1'b0;
        op_d   = kcm_pick_op(clr_i, force_i, inc_en_i | dec_en_i);
        base_d = st_q.idle ? '0 : {2'b00, st_q.cnt};
        inc_d  = inc_en_i ? {{(NW-AMT_W){1'b0}}, inc_amt_i} : '0;
        dec_d  = dec_en_i ? {{(NW-AMT_W){1'b0}}, dec_amt_i} : '0;
        net_d  = base_d + inc_d - dec_d;
        case (op_d)
            OP_CLEAR: st_d = RST_VAL;
            OP_FORCE: st_d = '{idle: 1'b0, cnt: '0};
            OP_ADJ: begin
                if (net_d[NW-1]) begin
                    rej_d = 1'b1;
                end else begin
                    st_d.idle = 1'b0;
                    st_d.cnt  = net_d[CNT_W-1:0];
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign idle_o   = st_q.idle;
    assign cnt_o    = st_q.cnt;
    assign reject_o = rej_d;

endmodule

// File: rtl/kcm_tracker.sv
module kcm_tracker
    import kcm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int AMT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kern_clear_i,
    input  logic             inv_inc_en_i,
    input  logic [AMT_W-1:0] inv_inc_amt_i,
    input  logic             inv_dec_en_i,
    input  logic [AMT_W-1:0] inv_dec_amt_i,
    input  logic             inv_force_i,
    input  logic             wb_inc_en_i,
    input  logic [AMT_W-1:0] wb_inc_amt_i,
    input  logic             wb_dec_en_i,
    input  logic [AMT_W-1:0] wb_dec_amt_i,
    output logic             inv_started_o,
    output logic             inv_done_o,
    output logic [CNT_W:0]   inv_count_o,
    output logic             wb_done_o,
    output logic [CNT_W-1:0] wb_count_o,
    output logic             count_err_o
);

    localparam int NCTR = 2;
    localparam int IDX_INV = 0;
    localparam int IDX_WB  = 1;

    logic             c_force [NCTR];
    logic             c_inc   [NCTR];
    logic             c_dec   [NCTR];
    logic [AMT_W-1:0] c_inca  [NCTR];
    logic [AMT_W-1:0] c_deca  [NCTR];
    logic             c_idle  [NCTR];
    logic [CNT_W-1:0] c_cnt   [NCTR];
    logic             c_rej   [NCTR];

    assign c_force[IDX_INV] = inv_force_i;
    assign c_inc[IDX_INV]   = inv_inc_en_i;
    assign c_inca[IDX_INV]  = inv_inc_amt_i;
    assign c_dec[IDX_INV]   = inv_dec_en_i;
    assign c_deca[IDX_INV]  = inv_dec_amt_i;
    assign c_force[IDX_WB]  = 1'b0;
    assign c_inc[IDX_WB]    = wb_inc_en_i;
    assign c_inca[IDX_WB]   = wb_inc_amt_i;
    assign c_dec[IDX_WB]    = wb_dec_en_i;
    assign c_deca[IDX_WB]   = wb_dec_amt_i;

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        kcm_counter #(
            .CNT_W       (CNT_W),
            .AMT_W       (AMT_W),
            .HAS_SENTINEL(g == IDX_INV)
        ) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (kern_clear_i),
            .force_i  (c_force[g]),
            .inc_en_i (c_inc[g]),
            .inc_amt_i(c_inca[g]),
            .dec_en_i (c_dec[g]),
            .dec_amt_i(c_deca[g]),
            .idle_o   (c_idle[g]),
            .cnt_o    (c_cnt[g]),
            .reject_o (c_rej[g])
        );
    end

    logic err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (kern_clear_i)                    err_d = 1'b0;
        else if (c_rej[IDX_INV] || c_rej[IDX_WB]) err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign inv_started_o = ~c_idle[IDX_INV];
    assign inv_done_o    = ~c_idle[IDX_INV] && (c_cnt[IDX_INV] == '0);
    assign inv_count_o   = c_idle[IDX_INV] ? '1 : {1'b0, c_cnt[IDX_INV]};
    assign wb_count_o    = c_cnt[IDX_WB];
    assign wb_done_o     = (c_cnt[IDX_WB] == '0);
    assign count_err_o   = err_q;

endmodule

// File: rtl/kcm_tracker_chk.sv
module kcm_tracker_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kern_clear_i,
    input logic             inv_force_i,
    input logic             inv_inc_en_i,
    input logic             inv_dec_en_i,
    input logic             inv_started_o,
    input logic             inv_done_o,
    input logic [CNT_W:0]   inv_count_o,
    input logic [CNT_W-1:0] wb_count_o,
    input logic             count_err_o
);

    // R2
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kern_clear_i |=> (inv_count_o == '1 && wb_count_o == '0 && !count_err_o));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_err_o && !kern_clear_i) |=> count_err_o);

    // R5
    force_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_force_i && !kern_clear_i) |=> inv_done_o);

    // R4
    started_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_started_o && !kern_clear_i) |=> inv_started_o);

    // R3
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!kern_clear_i && !inv_force_i && !inv_inc_en_i && !inv_dec_en_i)
        |=> $stable(inv_count_o));

endmodule

bind kcm_tracker kcm_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kern_clear_i (kern_clear_i),
    .inv_force_i  (inv_force_i),
    .inv_inc_en_i (inv_inc_en_i),
    .inv_dec_en_i (inv_dec_en_i),
    .inv_started_o(inv_started_o),
    .inv_done_o   (inv_done_o),
    .inv_count_o  (inv_count_o),
    .wb_count_o   (wb_count_o),
    .count_err_o  (count_err_o)
);

// File: tb/sim_kcm_tracker.sv
`timescale 1ns/1ps
module sim_kcm_tracker;

    localparam int CNT_W = 8;
    localparam int AMT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kern_clear_i = 0, inv_inc_en_i = 0, inv_dec_en_i = 0, inv_force_i = 0;
    logic wb_inc_en_i = 0, wb_dec_en_i = 0;
    logic [AMT_W-1:0] inv_inc_amt_i = 0, inv_dec_amt_i = 0, wb_inc_amt_i = 0, wb_dec_amt_i = 0;
    logic inv_started_o, inv_done_o, wb_done_o, count_err_o;
    logic [CNT_W:0] inv_count_o;
    logic [CNT_W-1:0] wb_count_o;

    always #2 clk = ~clk;

    kcm_tracker #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    int m_idle, m_inv, m_wb, m_err;
    int seed;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "inv_count", int'($signed(inv_count_o)), m_idle ? -1 : m_inv);
        chk("R4", "inv_started", int'(inv_started_o), m_idle ? 0 : 1);
        chk("R4", "inv_done", int'(inv_done_o), (!m_idle && m_inv == 0) ? 1 : 0);
        chk(req, "wb_count", int'(wb_count_o), m_wb);
        chk("R6", "wb_done", int'(wb_done_o), (m_wb == 0) ? 1 : 0);
        chk(req, "count_err", int'(count_err_o), m_err);
    endtask

    function automatic int eff(input logic en, input logic [AMT_W-1:0] a);
        return en ? int'(a) : 0;
    endfunction

    task automatic model_step();
        int n;
        if (kern_clear_i) begin
            m_idle = 1; m_inv = 0; m_wb = 0; m_err = 0;
            return;
        end
        if (inv_force_i) begin
            m_idle = 0; m_inv = 0;
        end else if (inv_inc_en_i || inv_dec_en_i) begin
            n = (m_idle ? 0 : m_inv) + eff(inv_inc_en_i, inv_inc_amt_i) - eff(inv_dec_en_i, inv_dec_amt_i);
            if (n < 0) m_err = 1;
            else begin m_idle = 0; m_inv = n; end
        end
        if (wb_inc_en_i || wb_dec_en_i) begin
            n = m_wb + eff(wb_inc_en_i, wb_inc_amt_i) - eff(wb_dec_en_i, wb_dec_amt_i);
            if (n < 0) m_err = 1;
            else m_wb = n;
        end
    endtask

    task automatic idle_inputs();
        kern_clear_i = 0; inv_inc_en_i = 0; inv_dec_en_i = 0; inv_force_i = 0;
        wb_inc_en_i = 0; wb_dec_en_i = 0;
        inv_inc_amt_i = 0; inv_dec_amt_i = 0; wb_inc_amt_i = 0; wb_dec_amt_i = 0;
    endtask

    // Inputs already set after a negedge; advance one edge and compare.
    task automatic step(input string req);
        @(posedge clk);
        model_step();
        #1;
        check_all(req);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed = 32'h1234_5678;
        void'($urandom(seed));
        m_idle = 1; m_inv = 0; m_wb = 0; m_err = 0;
        repeat (3) @(negedge clk);
        #1;
        check_all("R1");
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R7: decrement from sentinel is refused
        inv_dec_en_i = 1; inv_dec_amt_i = 1;
        step("R7");
        // R8: error stays with no strobes
        step("R8");
        kern_clear_i = 1;
        step("R2");

        // R4: zero-net update from sentinel -> started and done
        inv_inc_en_i = 1; inv_inc_amt_i = 0;
        step("R4");

        // R3: plain increments
        inv_inc_en_i = 1; inv_inc_amt_i = 7;
        step("R3");
        // R9: equal inc and dec
        inv_inc_en_i = 1; inv_inc_amt_i = 5; inv_dec_en_i = 1; inv_dec_amt_i = 5;
        step("R9");
        // R9: dec 9 > count 7 but net positive with inc 4
        inv_inc_en_i = 1; inv_inc_amt_i = 4; inv_dec_en_i = 1; inv_dec_amt_i = 9;
        step("R9");
        // R3: retire to zero
        inv_dec_en_i = 1; inv_dec_amt_i = 2;
        step("R3");

        // R6 / R7: wb underflow alongside valid inv update
        wb_inc_en_i = 1; wb_inc_amt_i = 3;
        step("R6");
        wb_dec_en_i = 1; wb_dec_amt_i = 5; inv_inc_en_i = 1; inv_inc_amt_i = 6;
        step("R7");
        wb_dec_en_i = 1; wb_dec_amt_i = 3;
        step("R6");

        // R5: force overrides same-cycle adjustments
        inv_force_i = 1; inv_inc_en_i = 1; inv_inc_amt_i = 9;
        step("R5");
        // R5: force from sentinel
        kern_clear_i = 1;
        step("R2");
        inv_force_i = 1; inv_dec_en_i = 1; inv_dec_amt_i = 3;
        step("R5");

        // R2: clear overrides everything
        inv_inc_en_i = 1; inv_inc_amt_i = 3; wb_inc_en_i = 1; wb_inc_amt_i = 2;
        step("R3");
        kern_clear_i = 1; inv_force_i = 1; inv_inc_en_i = 1; inv_inc_amt_i = 4;
        wb_inc_en_i = 1; wb_inc_amt_i = 4; wb_dec_en_i = 1; wb_dec_amt_i = 15;
        step("R2");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            kern_clear_i  = ($urandom % 64) == 0;
            inv_force_i   = ($urandom % 32) == 0;
            inv_inc_en_i  = (($urandom % 3) == 0) && (m_inv < 200);
            inv_inc_amt_i = AMT_W'($urandom);
            inv_dec_en_i  = ($urandom % 3) == 0;
            inv_dec_amt_i = AMT_W'($urandom % 6);
            wb_inc_en_i   = (($urandom % 3) == 0) && (m_wb < 200);
            wb_inc_amt_i  = AMT_W'($urandom);
            wb_dec_en_i   = ($urandom % 3) == 0;
            wb_dec_amt_i  = AMT_W'($urandom % 6);
            step("R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule